// File: doc/BRIEF.md
# Add/Subtract Unit with Carry Flags

This block is the integer add/subtract datapath of a processor execute stage. It forms a result from a first operand and a second operand that is already prepared. The second operand may be shifted or an immediate, and that preparation happens outside this block. Six operations are selected by a 3-bit code: plain add, add with carry, subtract, subtract with carry, reverse subtract, and reverse subtract with carry. The result is purely combinational. Four condition flags (negative, zero, carry, overflow) sit in a register. That register loads only on a clock edge where the set-flags input is high, and the flags feed back as the carry input of the with-carry operations.

For subtraction, carry follows the not-borrow convention: carry is 1 when no borrow occurs. A with-carry subtract therefore takes away one extra only when the stored carry is clear. Because of this, a wide integer can be added or subtracted one word at a time. The lowest word is done with flags set, and each higher word uses the with-carry form.

A program-counter mode replaces the first operand with the instruction address plus 8. An align control forces the two low bits of that value to zero, which gives word-aligned PC-relative address generation.

Top module: `addsub_unit`

## Requirements
- R1: Operation codes are 0 = add (A+B), 2 = subtract (A−B) and 4 = reverse subtract (B−A). Codes 6 and 7 behave as code 0. The result is modulo 2^W and appears combinationally.
- R2: Code 1 (add with carry) gives A+B+C, where C is the stored carry flag.
- R3: Code 3 (subtract with carry) gives A−B−1 when C is 0 and A−B when C is 1. Code 5 (reverse subtract with carry) gives B−A−1 when C is 0 and B−A when C is 1.
- R4: After a flag-setting operation, the carry flag is the unsigned carry out for the add codes. For the subtract codes it is 1 exactly when no borrow occurred, meaning the unsigned minuend is at least the subtrahend plus the borrow-in.
- R5: After a flag-setting operation, N equals the result MSB and Z is 1 exactly when the result is zero. V is 1 exactly when the two's-complement result of the operation lies outside the signed W-bit range.
- R6: The flags change only on a rising clock edge with set_flags high. With set_flags low, all four flags hold their values.
- R7: With pc_src high, the first operand is inst_addr + 8 (modulo 2^W) instead of opa.
- R8: With pc_src and pc_align both high, bits [1:0] of the first operand are forced to 0 after the +8. pc_align has no effect while pc_src is low.
- R9: While rst_n is low, all four flags are 0.
- R10: A two-word add (low word with code 0, then high word with code 1) gives the correct double-width sum. The same holds for a two-word subtract (low word with code 2, then high word with code 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op | input | 3 | Operation code |
| set_flags | input | 1 | Load the flags from this operation at the next edge |
| pc_src | input | 1 | Use inst_addr + 8 as the first operand |
| pc_align | input | 1 | Clear bits [1:0] of the PC operand |
| opa | input | W | First operand |
| opb | input | W | Second operand, already shifted or zero-extended |
| inst_addr | input | W | Address of the current instruction |
| result | output | W | Arithmetic result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The only internal state is the flag register, and a wrong carry bit in it shows up in two places. It appears at flag_c one cycle after a flag-setting operation. It also appears in the result of the very next with-carry operation, off by one. Each vector is therefore preceded by a flag-setting operation that plants a known carry. The result is then checked in the same cycle and the new flags on the following edge, over near-exhaustive operand sweeps of an 8-bit instance. Holding behaviour, the PC operand and two-word chains are checked with directed sequences.

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic         set_flags,
  input  logic         pc_src,
  input  logic         pc_align,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] inst_addr,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam logic [W-1:0] PC_OFS = W'(8);
  localparam logic [W-1:0] ALIGN_MASK = ~W'(3);

  logic [W-1:0] pc_val, first, x, y;
  logic         cin;
  logic [W:0]   sum;

  assign pc_val = inst_addr + PC_OFS;
  assign first  = pc_src ? (pc_align ? (pc_val & ALIGN_MASK) : pc_val) : opa;

  always_comb begin
    x   = first;
    y   = opb;
    cin = 1'b0;
    case (op)
      3'd1: cin = flag_c;
      3'd2: begin y = ~opb;  cin = 1'b1;   end
      3'd3: begin y = ~opb;  cin = flag_c; end
      3'd4: begin x = opb; y = ~first; cin = 1'b1;   end
      3'd5: begin x = opb; y = ~first; cin = flag_c; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign result = sum[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {flag_n, flag_z, flag_c, flag_v} <= 4'b0;
    end else if (set_flags) begin
      flag_n <= sum[W-1];
      flag_z <= (sum[W-1:0] == '0);
      flag_c <= sum[W];
      flag_v <= (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
  end
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic         set_flags,
  input logic         pc_src,
  input logic         pc_align,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v
);
  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_z == ($past(result) == '0)));

  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_n == $past(result[W-1])));

  // R4
  equal_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op == 3'd2 && !pc_src && opa == opb) |=> (flag_c && flag_z && !flag_v));

  // R8
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src && pc_align && op == 3'd0 && opb == '0) |-> (result[1:0] == 2'b00));

  // R9
  reset_flags_chk: assert property (@(posedge clk)
    !rst_n |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0));
endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op(op), .set_flags(set_flags), .pc_src(pc_src),
  .pc_align(pc_align), .opa(opa), .opb(opb), .result(result),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/addsub_unit_test.sv
module addsub_unit_test;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic set_flags = 1'b0, pc_src = 1'b0, pc_align = 1'b0;
  logic [TW-1:0] opa = '0, opb = '0, inst_addr = '0;
  logic [TW-1:0] result;
  logic flag_n, flag_z, flag_c, flag_v;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addsub_unit #(.W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .set_flags(set_flags), .pc_src(pc_src),
    .pc_align(pc_align), .opa(opa), .opb(opb), .inst_addr(inst_addr),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int u);
    return (u > 127) ? u - 256 : u;
  endfunction

  // expected {res, n, z, c, v} packed as res<<4 | nzcv
  function automatic int model(input int code, input int a, input int b, input int ci);
    int u, s, c, r;
    case (code)
      1:       begin u = a + b + ci;      s = sgn(a) + sgn(b) + ci;      c = (u > 255); end
      2:       begin u = a - b;           s = sgn(a) - sgn(b);           c = (u >= 0);  end
      3:       begin u = a - b - (1-ci);  s = sgn(a) - sgn(b) - (1-ci);  c = (u >= 0);  end
      4:       begin u = b - a;           s = sgn(b) - sgn(a);           c = (u >= 0);  end
      5:       begin u = b - a - (1-ci);  s = sgn(b) - sgn(a) - (1-ci);  c = (u >= 0);  end
      default: begin u = a + b;           s = sgn(a) + sgn(b);           c = (u > 255); end
    endcase
    r = u & 255;
    return (r << 4) | (((r >> 7) & 1) << 3) | ((r == 0) << 2) | (c << 1)
           | ((s > 127 || s < -128) ? 1 : 0);
  endfunction

  task automatic plant_carry(input int ci);
    @(negedge clk);
    op = 3'd0; pc_src = 0; pc_align = 0; set_flags = 1;
    opa = (ci != 0) ? 8'hFF : 8'h00;
    opb = (ci != 0) ? 8'h01 : 8'h00;
    @(posedge clk);
  endtask

  task automatic apply(input int code, input int a, input int b, input bit sf);
    @(negedge clk);
    op = code[2:0]; opa = a[7:0]; opb = b[7:0]; set_flags = sf;
    #1;
  endtask

  function automatic int nzcv();
    return {28'd0, flag_n, flag_z, flag_c, flag_v};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int e, lo, hi, hr;
    // R9 reset state
    repeat (2) @(posedge clk);
    #1 check("R9 flags in reset", nzcv(), 0);
    @(negedge clk); rst_n = 1;

    // sweep: R1 R2 R3 R4 R5
    for (int code = 0; code < 8; code++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 256; a += 5)
          for (int b = 0; b < 256; b += 9) begin
            plant_carry(ci);
            apply(code, a, b, 1);
            e = model(code, a, b, ci);
            check((code == 1) ? "R2 result" : (code == 3 || code == 5) ? "R3 result" : "R1 result",
                  int'(result), e >> 4);
            @(posedge clk); #1;
            check("R4 R5 flags", nzcv(), e & 15);
          end

    // corner cases R4 R5
    plant_carry(0); apply(0, 8'h7F, 8'h01, 1); @(posedge clk); #1;
    check("R5 add overflow", nzcv(), 4'b1001);
    plant_carry(0); apply(2, 8'h80, 8'h01, 1); @(posedge clk); #1;
    check("R5 sub overflow", nzcv(), 4'b0011);
    plant_carry(1); apply(3, 8'h00, 8'h00, 1); @(posedge clk); #1;
    check("R4 sbc no borrow", nzcv(), 4'b0110);

    // R6 hold
    plant_carry(1);
    apply(2, 8'h05, 8'h09, 0); @(posedge clk); #1;
    check("R6 hold after sub", nzcv(), 4'b0110);
    apply(0, 8'h80, 8'h80, 0); @(posedge clk); #1;
    check("R6 hold after add", nzcv(), 4'b0110);

    // R7 R8 PC operand
    for (int pa = 0; pa < 256; pa += 13) begin
      @(negedge clk);
      inst_addr = pa[7:0]; pc_src = 1; pc_align = 0; op = 3'd0;
      opa = 8'h5A; opb = 8'h00; set_flags = 0;
      #1 check("R7 pc plus 8", int'(result), (pa + 8) & 255);
      pc_align = 1;
      #1 check("R8 pc aligned", int'(result), (pa + 8) & 252);
      op = 3'd2; opb = 8'h03;
      #1 check("R8 aligned sub", int'(result), (((pa + 8) & 252) - 3) & 255);
      pc_src = 0;
      #1 check("R8 align ignored", int'(result), (8'h5A - 3) & 255);
    end
    @(negedge clk); pc_align = 0;

    // R10 two-word chains
    for (int k = 0; k < 40; k++) begin
      lo = (k * 2897 + 123) & 16'hFFFF;
      hi = (k * 40503 + 7) & 16'hFFFF;
      apply(0, lo & 255, hi & 255, 1); hr = result;
      @(posedge clk);
      apply(1, lo >> 8, hi >> 8, 0);
      check("R10 two-word add", (int'(result) << 8) | hr, (lo + hi) & 16'hFFFF);
      apply(2, lo & 255, hi & 255, 1); hr = result;
      @(posedge clk);
      apply(3, lo >> 8, hi >> 8, 0);
      check("R10 two-word sub", (int'(result) << 8) | hr, (lo - hi) & 16'hFFFF);
    end

    // R9 reset again clears flags
    plant_carry(1);
    @(negedge clk); set_flags = 0; rst_n = 0;
    #1 check("R9 async reset", nzcv(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule